// File: doc/BRIEF.md
# Valid-Bit Doorbell Work Queue

A circular queue of fixed-width command entries shared between one producer and one consumer. Each side owns a single pointer and never reads the other's. Every slot carries its own valid bit, and that bit is the only occupancy information. The producer may fill the slot at its next-free pointer only while that slot's valid bit is clear. An accepted write stores the entry, sets the bit and advances the pointer. The consumer takes the slot at its next-to-service pointer while that slot's valid bit is set, clears the bit and advances. It stops as soon as it reaches a clear bit.

Every accepted write sends a one-cycle doorbell pulse toward the consumer. It also sets a pending flag that stays high until the consumer acknowledges it, so a doorbell cannot be lost. Entries leave in the order they arrived. The block does not reorder them and does not interpret their contents. A send path and a receive path are built from two instances with the producer and consumer roles swapped.

Top module: `vbit_work_queue`

## Requirements
- R1: After reset every valid bit is clear. prod_full, cons_avail, doorbell and pend are all 0.
- R2: A push is accepted when prod_push is high and prod_full is low. The entry is stored in the next-free slot and that slot's valid bit is set. From the following cycle cons_avail is 1, and cons_data shows the oldest unconsumed entry.
- R3: Entries are presented to the consumer in push order, including across the wrap from the last slot back to slot 0.
- R4: prod_full is 1 exactly when the slot at the producer pointer still has its valid bit set. A push while prod_full is 1 is ignored: nothing is stored, the pointer does not move and no doorbell fires.
- R5: A pop is accepted when cons_pop is high and cons_avail is 1. It clears the valid bit of the serviced slot and advances the consumer pointer. A pop while cons_avail is 0 is ignored.
- R6: A push and a pop in the same cycle both take effect.
- R7: doorbell is a single-cycle pulse in the cycle after each accepted push, and only then.
- R8: pend is set by an accepted push and holds until pend_ack is seen. If a push and pend_ack occur in the same cycle, pend stays set.
- R9: Occupancy comes only from the valid bits. With all DEPTH slots filled, prod_full and cons_avail are both 1. When no slot is valid, cons_avail is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_push | input | 1 | Producer write request |
| prod_data | input | WIDTH | Entry to store |
| prod_full | output | 1 | Slot at the producer pointer is still valid |
| cons_pop | input | 1 | Consumer takes the current entry |
| cons_avail | output | 1 | Slot at the consumer pointer is valid |
| cons_data | output | WIDTH | Entry at the consumer pointer |
| doorbell | output | 1 | One-cycle pulse per accepted push |
| pend | output | 1 | Sticky doorbell-pending flag |
| pend_ack | input | 1 | Consumer clears the pending flag |

## Verification
The bench fills all sixteen slots starting from a non-zero pointer, so the wrap is exercised. It then pushes once more into the full queue. A design that overwrote a live slot would later show the rejected data or lose an older entry, and one that fired a doorbell anyway would show an extra pulse. It pops with the queue empty and then pushes. A consumer pointer that had moved on that empty pop would leave cons_avail low over the new entry. It pushes and pops in the same cycle, and it acknowledges in the same cycle as a push. Dropping either action in the first case, or letting the acknowledge win in the second, shows as the wrong head entry or a lost pending flag.

// File: rtl/vbit_work_queue.sv
module vbit_work_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_push,
  input  logic [WIDTH-1:0] prod_data,
  output logic             prod_full,
  input  logic             cons_pop,
  output logic             cons_avail,
  output logic [WIDTH-1:0] cons_data,
  output logic             doorbell,
  output logic             pend,
  input  logic             pend_ack
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    wp_q, rp_q;
  logic             take_in, take_out;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign prod_full  = vld_q[wp_q];
  assign cons_avail = vld_q[rp_q];
  assign cons_data  = slot_q[rp_q];
  assign take_in    = prod_push & ~prod_full;
  assign take_out   = cons_pop & cons_avail;

  always_ff @(posedge clk) begin
    if (take_in) slot_q[wp_q] <= prod_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else begin
      if (take_in) begin
        vld_q[wp_q] <= 1'b1;
        wp_q        <= step(wp_q);
      end
      if (take_out) begin
        vld_q[rp_q] <= 1'b0;
        rp_q        <= step(rp_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doorbell <= 1'b0;
      pend     <= 1'b0;
    end else begin
      doorbell <= take_in;
      if (take_in)       pend <= 1'b1;
      else if (pend_ack) pend <= 1'b0;
    end
  end

  // R2
  push_then_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_push && !prod_full |=> cons_avail);
  // R4
  full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_push && prod_full && !cons_pop |=> $stable(wp_q) && !doorbell);
  // R9
  full_implies_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_full |-> cons_avail);
  // R9
  empty_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_avail |-> vld_q == '0);
  // R7
  doorbell_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> pend);
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !pend_ack |=> pend);
  // R5
  idle_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_avail && !prod_push |=> $stable(rp_q));
endmodule

// File: tb/sim_vbit_work_queue.sv
module sim_vbit_work_queue;
  localparam int DEPTH = 16;
  localparam int WIDTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prod_push = 1'b0, cons_pop = 1'b0, pend_ack = 1'b0;
  logic [WIDTH-1:0] prod_data = '0;
  logic prod_full, cons_avail, doorbell, pend;
  logic [WIDTH-1:0] cons_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  vbit_work_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .prod_push(prod_push), .prod_data(prod_data),
    .prod_full(prod_full), .cons_pop(cons_pop), .cons_avail(cons_avail),
    .cons_data(cons_data), .doorbell(doorbell), .pend(pend), .pend_ack(pend_ack));

  task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic p, input logic [WIDTH-1:0] d, input logic q, input logic a);
    prod_push = p; prod_data = d; cons_pop = q; pend_ack = a;
    @(posedge clk); #2;
    prod_push = 1'b0; cons_pop = 1'b0; pend_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 full", prod_full, 0);
    chk("R1 avail", cons_avail, 0);
    chk("R1 doorbell", doorbell, 0);
    chk("R1 pend", pend, 0);
  endtask

  task automatic t_single();
    tick(1, 64'hA1, 0, 0);
    chk("R2 avail", cons_avail, 1);
    chk("R2 data", cons_data, 64'hA1);
    chk("R7 pulse", doorbell, 1);
    chk("R8 set", pend, 1);
    tick(0, 0, 0, 0);
    chk("R7 single cycle", doorbell, 0);
    chk("R8 hold", pend, 1);
    tick(0, 0, 0, 1);
    chk("R8 ack", pend, 0);
    tick(0, 0, 1, 0);
    chk("R5 pop empties", cons_avail, 0);
    tick(0, 0, 1, 0);
    chk("R5 empty pop avail", cons_avail, 0);
    chk("R5 empty pop full", prod_full, 0);
    tick(1, 64'hB2, 0, 0);
    chk("R5 pointer kept", cons_avail, 1);
    chk("R5 data after idle pop", cons_data, 64'hB2);
    tick(0, 0, 1, 0);
    chk("R9 empty", cons_avail, 0);
  endtask

  task automatic t_fill_wrap();
    for (int i = 0; i < DEPTH; i++) begin
      tick(1, 64'h1000 + 64'(i), 0, 0);
      chk("R7 pulse each push", doorbell, 1);
    end
    chk("R4 full", prod_full, 1);
    chk("R9 full and avail", cons_avail, 1);
    tick(1, 64'hDEAD, 0, 1);
    chk("R7 no pulse on rejected push", doorbell, 0);
    chk("R4 still full", prod_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 order", cons_data, 64'h1000 + 64'(i));
      tick(0, 0, 1, 0);
      chk("R4 not full after pop", prod_full, 0);
    end
    chk("R9 drained", cons_avail, 0);
  endtask

  task automatic t_simul();
    tick(1, 64'hC3, 0, 0);
    tick(1, 64'hC4, 1, 1);
    chk("R6 both avail", cons_avail, 1);
    chk("R6 head is new entry", cons_data, 64'hC4);
    chk("R8 push beats ack", pend, 1);
    tick(0, 0, 1, 0);
    chk("R6 single left", cons_avail, 0);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_single();
    t_fill_wrap();
    t_simul();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule